// File: doc/BRIEF.md
# Full-Search SAD Motion Estimator

This block finds the best match for a small square block of the current picture inside a local search area of the previous picture. Software or a surrounding datapath first writes the current block and the search window into two on-chip pixel stores, then pulses `start`. The engine walks every candidate displacement within plus or minus the search range in both directions. For each one it forms the sum of absolute differences between the current block and the shifted window patch, and it keeps the smallest sum seen so far.

The scan handles one absolute difference per clock. When the last candidate has been scored, `done` pulses for one cycle. The winning displacement appears on `mv_row`/`mv_col` as signed values and the matching distortion on `min_sad`. These outputs hold until the next search completes. Candidates are visited in a fixed order: row displacement in the outer loop and column displacement in the inner loop, both counting upward. Because the minimum only moves on a strictly smaller sum, the first candidate in that order wins any tie.

Top module: `me_full_search`

## Requirements
- R1: After synchronous reset, `busy` and `done` are 0, and `mv_row`, `mv_col` and `min_sad` are all 0.
- R2: The current block pixel at (row i, column j) is written at `cur_addr` = i*BLK + j. The window pixel at (row r, column c) is written at `win_addr` = r*(BLK+2*RNG) + c. For displacement (m, n), the distortion is the sum over all i, j of |cur(i,j) - win(i+m+RNG, j+n+RNG)|. `min_sad` reports the smallest distortion over all (2*RNG+1)^2 displacements.
- R3: `mv_row` carries m and `mv_col` carries n of the reported minimum, both as two's-complement values in the range -RNG..+RNG.
- R4: Candidates are scored with m as the outer loop and n as the inner loop, each running from -RNG to +RNG. The stored best changes only on a strictly smaller distortion, so on a tie the earliest candidate in this order is reported.
- R5: `done` is a single-cycle pulse. It rises exactly BLK*BLK*(2*RNG+1)^2 + 2 clock edges after the edge that accepted `start`. `busy` is high from the accepting edge until `done` rises, and is low while `done` is high.
- R6: A `start` pulse while `busy` is high is ignored: the running search is neither restarted nor lengthened, and no extra `done` follows.
- R7: A `start` asserted in the cycle where `done` is high is accepted and launches a new search with the same timing.
- R8: Pixel writes made while idle are used by the next search. `mv_row`, `mv_col` and `min_sad` stay constant except in the cycle that `done` rises.
- R9: The distortion register is PIX_W + 2*log2(BLK) bits wide and reports the worst case BLK*BLK*(2^PIX_W - 1) exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_we | input | 1 | Current block pixel write enable |
| cur_addr | input | log2(BLK*BLK) | Current block write address, i*BLK + j |
| cur_data | input | PIX_W | Current block pixel value |
| win_we | input | 1 | Search window pixel write enable |
| win_addr | input | log2((BLK+2*RNG)^2) | Window write address, row*(BLK+2*RNG) + col |
| win_data | input | PIX_W | Window pixel value |
| start | input | 1 | Launch request, taken only while idle |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| mv_row | output | log2(RNG+1)+1 | Signed row displacement of best match |
| mv_col | output | log2(RNG+1)+1 | Signed column displacement of best match |
| min_sad | output | PIX_W+2*log2(BLK) | Distortion of best match |

## Verification
Two events can land on the same clock: finishing one search and accepting the next `start`. The bench raises `start` in the very cycle that `done` is high. It then requires a second `done` exactly one full search later, with the correct result. Another case sends a `start` deep inside a running search; the bench requires the original completion time to be unchanged and no second pulse afterwards. Every result is compared against an exhaustive arithmetic search done in the bench over the same pixels. The pixel sets include random data, a copied patch, a periodic window that forces exact ties, a flat picture and the all-maximum difference.

// File: rtl/me_search_pkg.sv
`timescale 1ns/1ps
package me_search_pkg;

  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_RUN  = 1'b1
  } eng_state_t;

  // Linear address of a pixel in a row-major square store.
  function automatic int grid_index(input int row, input int col, input int width);
    return row * width + col;
  endfunction

endpackage

// File: rtl/me_pix_ram.sv
`timescale 1ns/1ps
module me_pix_ram #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  // Simple dual-port store: one write port, one registered read port.
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/me_scan_ctrl.sv
`timescale 1ns/1ps
module me_scan_ctrl
  import me_search_pkg::*;
#(
  parameter int BLK    = 4,
  parameter int SPAN   = 5,
  parameter int WIN    = 8,
  parameter int CUR_AW = 4,
  parameter int WIN_AW = 6,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  output logic              run,
  output logic [CUR_AW-1:0] cur_raddr,
  output logic [WIN_AW-1:0] win_raddr,
  output logic              first_pix,
  output logic              last_pix,
  output logic              last_cand,
  output logic [OFF_W-1:0]  m_off,
  output logic [OFF_W-1:0]  n_off
);

  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(BLK - 1);
  localparam logic [OFF_W-1:0] OFF_MAX = OFF_W'(SPAN - 1);

  logic [IDX_W-1:0] i_q, j_q;
  logic [OFF_W-1:0] m_q, n_q;
  logic             run_q;
  logic             j_end, i_end, n_end, m_end;

  assign j_end = (j_q == IDX_MAX);
  assign i_end = (i_q == IDX_MAX);
  assign n_end = (n_q == OFF_MAX);
  assign m_end = (m_q == OFF_MAX);

  // Counter nest: j fastest, then i, then n, then m (outermost).
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      i_q   <= '0;
      j_q   <= '0;
      m_q   <= '0;
      n_q   <= '0;
    end else if (launch) begin
      run_q <= 1'b1;
      i_q   <= '0;
      j_q   <= '0;
      m_q   <= '0;
      n_q   <= '0;
    end else if (run_q) begin
      if (!j_end) begin
        j_q <= j_q + 1'b1;
      end else begin
        j_q <= '0;
        if (!i_end) begin
          i_q <= i_q + 1'b1;
        end else begin
          i_q <= '0;
          if (!n_end) begin
            n_q <= n_q + 1'b1;
          end else begin
            n_q <= '0;
            if (!m_end) begin
              m_q <= m_q + 1'b1;
            end else begin
              m_q   <= '0;
              run_q <= 1'b0;
            end
          end
        end
      end
    end
  end

  assign run       = run_q;
  assign first_pix = run_q && (i_q == '0) && (j_q == '0);
  assign last_pix  = run_q && i_end && j_end;
  assign last_cand = last_pix && m_end && n_end;
  assign m_off     = m_q;
  assign n_off     = n_q;

  assign cur_raddr = CUR_AW'(grid_index(int'(i_q), int'(j_q), BLK));
  assign win_raddr = WIN_AW'(grid_index(int'(i_q) + int'(m_q), int'(j_q) + int'(n_q), WIN));

  // R2: all scan indices stay inside the stores while the scan runs.
  p_idx_range_r2: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (int'(i_q) < BLK) && (int'(j_q) < BLK) && (int'(m_q) < SPAN) && (int'(n_q) < SPAN));

  // R6: a launch never arrives on top of a running scan.
  p_no_relaunch_r6: assert property (@(posedge clk) disable iff (rst)
    run_q |-> !launch);

endmodule

// File: rtl/me_sad_acc.sv
`timescale 1ns/1ps
module me_sad_acc #(
  parameter int PIX_W = 8,
  parameter int SAD_W = 12,
  parameter int OFF_W = 3,
  parameter int N_PIX = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_v,
  input  logic             first_pix,
  input  logic             last_pix,
  input  logic             last_cand,
  input  logic [OFF_W-1:0] m_in,
  input  logic [OFF_W-1:0] n_in,
  input  logic [PIX_W-1:0] cur_px,
  input  logic [PIX_W-1:0] win_px,
  output logic             sad_v,
  output logic [SAD_W-1:0] sad,
  output logic             sad_last,
  output logic [OFF_W-1:0] m_out,
  output logic [OFF_W-1:0] n_out
);

  localparam int SAD_CAP = N_PIX * ((1 << PIX_W) - 1);

  logic [PIX_W-1:0] absdiff;
  logic [SAD_W-1:0] acc_q;
  logic [SAD_W-1:0] base;
  logic [SAD_W-1:0] sum;

  assign absdiff = (cur_px >= win_px) ? (cur_px - win_px) : (win_px - cur_px);
  assign base    = first_pix ? '0 : acc_q;
  assign sum     = base + SAD_W'(absdiff);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      sad_v    <= 1'b0;
      sad      <= '0;
      sad_last <= 1'b0;
      m_out    <= '0;
      n_out    <= '0;
    end else begin
      sad_v <= in_v && last_pix;
      if (in_v) begin
        acc_q <= sum;
      end
      if (in_v && last_pix) begin
        sad      <= sum;
        sad_last <= last_cand;
        m_out    <= m_in;
        n_out    <= n_in;
      end
    end
  end

  // R9: a finished distortion never exceeds the worst case for the block.
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    sad_v |-> (int'(sad) <= SAD_CAP));

  // R2: accumulation only grows within a candidate.
  p_acc_grows_r2: assert property (@(posedge clk) disable iff (rst)
    in_v && !first_pix |=> acc_q >= $past(acc_q));

endmodule

// File: rtl/me_best_pick.sv
`timescale 1ns/1ps
module me_best_pick #(
  parameter int SAD_W = 12,
  parameter int OFF_W = 3,
  parameter int MV_W  = 3,
  parameter int RNG   = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    launch,
  input  logic                    sad_v,
  input  logic [SAD_W-1:0]        sad,
  input  logic                    sad_last,
  input  logic [OFF_W-1:0]        m_in,
  input  logic [OFF_W-1:0]        n_in,
  output logic                    done,
  output logic signed [MV_W-1:0]  mv_row,
  output logic signed [MV_W-1:0]  mv_col,
  output logic [SAD_W-1:0]        min_sad
);

  localparam logic [OFF_W-1:0] CENTER = OFF_W'(RNG);

  logic [SAD_W-1:0] best_sad;
  logic [OFF_W-1:0] best_m, best_n;
  logic             better;
  logic [SAD_W-1:0] nxt_sad;
  logic [OFF_W-1:0] nxt_m, nxt_n;

  // Strictly smaller wins; a tie keeps the earlier candidate.
  assign better  = sad_v && (sad < best_sad);
  assign nxt_sad = better ? sad  : best_sad;
  assign nxt_m   = better ? m_in : best_m;
  assign nxt_n   = better ? n_in : best_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      best_sad <= '1;
      best_m   <= CENTER;
      best_n   <= CENTER;
    end else if (launch) begin
      best_sad <= '1;
      best_m   <= CENTER;
      best_n   <= CENTER;
    end else begin
      best_sad <= nxt_sad;
      best_m   <= nxt_m;
      best_n   <= nxt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      mv_row  <= '0;
      mv_col  <= '0;
      min_sad <= '0;
    end else begin
      done <= sad_v && sad_last;
      if (sad_v && sad_last) begin
        mv_row  <= MV_W'(nxt_m) - MV_W'(RNG);
        mv_col  <= MV_W'(nxt_n) - MV_W'(RNG);
        min_sad <= nxt_sad;
      end
    end
  end

  // R5: completion is a single-cycle pulse.
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4: within a search the stored best never rises.
  p_best_falls_r4: assert property (@(posedge clk) disable iff (rst)
    sad_v |=> best_sad <= $past(best_sad));

  // R3: reported vector components stay inside the search range.
  p_vec_range_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (int'(mv_row) >= -RNG) && (int'(mv_row) <= RNG) &&
             (int'(mv_col) >= -RNG) && (int'(mv_col) <= RNG));

  // R8: results are held between completions.
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(mv_row) && $stable(mv_col) && $stable(min_sad));

endmodule

// File: rtl/me_full_search.sv
`timescale 1ns/1ps
module me_full_search
  import me_search_pkg::*;
#(
  parameter int BLK   = 4,
  parameter int RNG   = 2,
  parameter int PIX_W = 8,
  localparam int WIN       = BLK + 2 * RNG,
  localparam int CUR_DEPTH = BLK * BLK,
  localparam int WIN_DEPTH = WIN * WIN,
  localparam int CUR_AW    = $clog2(CUR_DEPTH),
  localparam int WIN_AW    = $clog2(WIN_DEPTH),
  localparam int SAD_W     = PIX_W + 2 * $clog2(BLK),
  localparam int MV_W      = $clog2(RNG + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cur_we,
  input  logic [CUR_AW-1:0]       cur_addr,
  input  logic [PIX_W-1:0]        cur_data,
  input  logic                    win_we,
  input  logic [WIN_AW-1:0]       win_addr,
  input  logic [PIX_W-1:0]        win_data,
  input  logic                    start,
  output logic                    busy,
  output logic                    done,
  output logic signed [MV_W-1:0]  mv_row,
  output logic signed [MV_W-1:0]  mv_col,
  output logic [SAD_W-1:0]        min_sad
);

  localparam int SPAN  = 2 * RNG + 1;
  localparam int IDX_W = $clog2(BLK);
  localparam int OFF_W = $clog2(SPAN);

  eng_state_t state_q;
  logic       launch;
  logic       finish;

  // Scan stage outputs
  logic              scan_run;
  logic [CUR_AW-1:0] cur_raddr;
  logic [WIN_AW-1:0] win_raddr;
  logic              scan_first, scan_last, scan_lc;
  logic [OFF_W-1:0]  scan_m, scan_n;

  // Read stage (aligned with registered store outputs)
  logic              rd_v, rd_first, rd_last, rd_lc;
  logic [OFF_W-1:0]  rd_m, rd_n;
  logic [PIX_W-1:0]  cur_px, win_px;

  // Score stage
  logic              sad_v, sad_last;
  logic [SAD_W-1:0]  sad;
  logic [OFF_W-1:0]  sad_m, sad_n;

  assign launch = start && (state_q == ENG_IDLE);
  assign finish = sad_v && sad_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ENG_IDLE;
    end else if (launch) begin
      state_q <= ENG_RUN;
    end else if (finish) begin
      state_q <= ENG_IDLE;
    end
  end

  assign busy = (state_q == ENG_RUN);

  me_pix_ram #(.DEPTH(CUR_DEPTH), .AW(CUR_AW), .DW(PIX_W)) cur_store_i (
    .clk   (clk),
    .we    (cur_we),
    .waddr (cur_addr),
    .wdata (cur_data),
    .raddr (cur_raddr),
    .rdata (cur_px)
  );

  me_pix_ram #(.DEPTH(WIN_DEPTH), .AW(WIN_AW), .DW(PIX_W)) win_store_i (
    .clk   (clk),
    .we    (win_we),
    .waddr (win_addr),
    .wdata (win_data),
    .raddr (win_raddr),
    .rdata (win_px)
  );

  me_scan_ctrl #(
    .BLK(BLK), .SPAN(SPAN), .WIN(WIN), .CUR_AW(CUR_AW), .WIN_AW(WIN_AW),
    .IDX_W(IDX_W), .OFF_W(OFF_W)
  ) scan_i (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .run       (scan_run),
    .cur_raddr (cur_raddr),
    .win_raddr (win_raddr),
    .first_pix (scan_first),
    .last_pix  (scan_last),
    .last_cand (scan_lc),
    .m_off     (scan_m),
    .n_off     (scan_n)
  );

  // Delay the scan tags by the store read latency.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v     <= 1'b0;
      rd_first <= 1'b0;
      rd_last  <= 1'b0;
      rd_lc    <= 1'b0;
      rd_m     <= '0;
      rd_n     <= '0;
    end else begin
      rd_v     <= scan_run;
      rd_first <= scan_first;
      rd_last  <= scan_last;
      rd_lc    <= scan_lc;
      rd_m     <= scan_m;
      rd_n     <= scan_n;
    end
  end

  me_sad_acc #(.PIX_W(PIX_W), .SAD_W(SAD_W), .OFF_W(OFF_W), .N_PIX(CUR_DEPTH)) acc_i (
    .clk       (clk),
    .rst       (rst),
    .in_v      (rd_v),
    .first_pix (rd_first),
    .last_pix  (rd_last),
    .last_cand (rd_lc),
    .m_in      (rd_m),
    .n_in      (rd_n),
    .cur_px    (cur_px),
    .win_px    (win_px),
    .sad_v     (sad_v),
    .sad       (sad),
    .sad_last  (sad_last),
    .m_out     (sad_m),
    .n_out     (sad_n)
  );

  me_best_pick #(.SAD_W(SAD_W), .OFF_W(OFF_W), .MV_W(MV_W), .RNG(RNG)) pick_i (
    .clk      (clk),
    .rst      (rst),
    .launch   (launch),
    .sad_v    (sad_v),
    .sad      (sad),
    .sad_last (sad_last),
    .m_in     (sad_m),
    .n_in     (sad_n),
    .done     (done),
    .mv_row   (mv_row),
    .mv_col   (mv_col),
    .min_sad  (min_sad)
  );

  // R5: busy is low whenever the completion pulse is visible.
  p_busy_done_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R6: busy only rises in response to a start request.
  p_busy_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R5: the scan runs only while the engine is busy.
  p_scan_inside_r5: assert property (@(posedge clk) disable iff (rst)
    scan_run |-> busy);

endmodule

// File: tb/me_full_search_tb.sv
`timescale 1ns/1ps
module me_full_search_tb_top;

  localparam int BLK   = 4;
  localparam int RNG   = 2;
  localparam int PIX_W = 8;
  localparam int WIN   = BLK + 2 * RNG;
  localparam int NCUR  = BLK * BLK;
  localparam int NWIN  = WIN * WIN;
  localparam int SPAN  = 2 * RNG + 1;
  localparam int LAT   = NCUR * SPAN * SPAN + 2;

  logic clk = 1'b0;
  logic rst;
  logic cur_we, win_we, start;
  logic [3:0] cur_addr;
  logic [5:0] win_addr;
  logic [7:0] cur_data, win_data;
  logic busy, done;
  logic signed [2:0] mv_row, mv_col;
  logic [11:0] min_sad;

  always #2 clk = ~clk;

  me_full_search #(.BLK(BLK), .RNG(RNG), .PIX_W(PIX_W)) dut_i (
    .clk(clk), .rst(rst),
    .cur_we(cur_we), .cur_addr(cur_addr), .cur_data(cur_data),
    .win_we(win_we), .win_addr(win_addr), .win_data(win_data),
    .start(start), .busy(busy), .done(done),
    .mv_row(mv_row), .mv_col(mv_col), .min_sad(min_sad)
  );

  int checks = 0;
  int fails  = 0;
  int blk [NCUR];
  int win [NWIN];
  int exp_m, exp_n, exp_s;
  int unsigned seed = 32'h1234_5678;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rnd8();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'hff);
  endfunction

  // Exhaustive reference search, row displacement outer, strict less-than.
  task automatic model();
    int best;
    best = 1 << 30;
    exp_m = 0; exp_n = 0;
    for (int m = -RNG; m <= RNG; m++) begin
      for (int n = -RNG; n <= RNG; n++) begin
        int s;
        s = 0;
        for (int i = 0; i < BLK; i++) begin
          for (int j = 0; j < BLK; j++) begin
            int d;
            d = blk[i*BLK+j] - win[(i+m+RNG)*WIN + (j+n+RNG)];
            s += (d < 0) ? -d : d;
          end
        end
        if (s < best) begin
          best = s; exp_m = m; exp_n = n;
        end
      end
    end
    exp_s = best;
  endtask

  task automatic load_all();
    for (int k = 0; k < NCUR; k++) begin
      @(negedge clk);
      cur_we = 1'b1; cur_addr = 4'(k); cur_data = 8'(blk[k]);
    end
    for (int k = 0; k < NWIN; k++) begin
      @(negedge clk);
      cur_we = 1'b0;
      win_we = 1'b1; win_addr = 6'(k); win_data = 8'(win[k]);
    end
    @(negedge clk);
    cur_we = 1'b0; win_we = 1'b0;
  endtask

  // Pulses start (unless already high), counts edges until done is seen.
  task automatic run_search(input int poke_at, output int cyc);
    int dones;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    dones = 0;
    while (cyc < 2000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      start = (cyc == poke_at);
      if (done) break;
    end
    start = 1'b0;
  endtask

  task automatic check_result(input string tag);
    check({tag, " R2 min_sad"}, int'(min_sad), exp_s);
    check({tag, " R3 mv_row"},  int'(mv_row),  exp_m);
    check({tag, " R3 mv_col"},  int'(mv_col),  exp_n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int cyc;
    rst = 1'b1; cur_we = 0; win_we = 0; start = 0;
    cur_addr = 0; win_addr = 0; cur_data = 0; win_data = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 mv_row", int'(mv_row), 0);
    check("R1 mv_col", int'(mv_col), 0);
    check("R1 min_sad", int'(min_sad), 0);

    // Copied patches at several displacements (R2, R3, R5)
    for (int t = 0; t < 4; t++) begin
      int pm, pn;
      pm = (t * 3) % SPAN - RNG;
      pn = (t * 2 + 1) % SPAN - RNG;
      for (int k = 0; k < NWIN; k++) win[k] = rnd8();
      for (int i = 0; i < BLK; i++)
        for (int j = 0; j < BLK; j++)
          blk[i*BLK+j] = win[(i+pm+RNG)*WIN + (j+pn+RNG)];
      load_all();
      model();
      run_search(-1, cyc);
      check("R5 latency copy", cyc, LAT);
      check_result("copy");
    end

    // Fully random block and window: nonzero minimum
    for (int t = 0; t < 3; t++) begin
      for (int k = 0; k < NWIN; k++) win[k] = rnd8();
      for (int k = 0; k < NCUR; k++) blk[k] = rnd8();
      load_all();
      model();
      run_search(-1, cyc);
      check("R5 latency random", cyc, LAT);
      check_result("random");
    end

    // R4: periodic rows give exact ties at m = -2, 0, +2; earliest wins
    for (int c = 0; c < WIN; c++) begin
      int a, b;
      a = rnd8(); b = rnd8();
      for (int r = 0; r < WIN; r++) win[r*WIN+c] = (r % 2 == 0) ? a : b;
    end
    for (int i = 0; i < BLK; i++)
      for (int j = 0; j < BLK; j++)
        blk[i*BLK+j] = win[(i+RNG)*WIN + (j+1+RNG)];
    load_all();
    model();
    run_search(-1, cyc);
    check_result("tie R4");
    check("R4 earliest row", int'(mv_row), -RNG);

    // R4: flat picture, every candidate ties
    for (int k = 0; k < NWIN; k++) win[k] = 77;
    for (int k = 0; k < NCUR; k++) blk[k] = 77;
    load_all();
    run_search(-1, cyc);
    check("R4 flat min_sad", int'(min_sad), 0);
    check("R4 flat mv_row", int'(mv_row), -RNG);
    check("R4 flat mv_col", int'(mv_col), -RNG);

    // R9: worst-case distortion
    for (int k = 0; k < NWIN; k++) win[k] = 0;
    for (int k = 0; k < NCUR; k++) blk[k] = 255;
    load_all();
    run_search(-1, cyc);
    check("R9 max sad", int'(min_sad), NCUR * 255);
    check("R9 mv_row", int'(mv_row), -RNG);

    // R8: outputs held while new pixels are written, new data used next
    begin
      int hs, hr, hc;
      hs = int'(min_sad); hr = int'(mv_row); hc = int'(mv_col);
      for (int k = 0; k < NWIN; k++) win[k] = rnd8();
      for (int i = 0; i < BLK; i++)
        for (int j = 0; j < BLK; j++)
          blk[i*BLK+j] = win[(i+1+RNG)*WIN + (j+2+RNG)];
      load_all();
      check("R8 hold min_sad", int'(min_sad), hs);
      check("R8 hold mv_row", int'(mv_row), hr);
      check("R8 hold mv_col", int'(mv_col), hc);
      model();
      run_search(-1, cyc);
      check_result("R8 reload");
    end

    // R6: start mid-search is ignored
    run_search(150, cyc);
    check("R6 latency with stray start", cyc, LAT);
    check_result("R6");
    begin
      int extra;
      extra = 0;
      for (int k = 0; k < LAT + 20; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      check("R6 no extra done", extra, 0);
      check("R6 idle busy", int'(busy), 0);
    end

    // R7: start raised in the done cycle launches a new search
    for (int k = 0; k < NWIN; k++) win[k] = rnd8();
    for (int k = 0; k < NCUR; k++) blk[k] = rnd8();
    load_all();
    model();
    run_search(-1, cyc);
    check("R7 first done", int'(done), 1);
    check("R5 busy low at done", int'(busy), 0);
    run_search(-1, cyc);
    check("R7 back-to-back latency", cyc, LAT);
    check_result("R7");
    @(negedge clk);
    check("R5 done single cycle", int'(done), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule